// File: doc/BRIEF.md
# External Interrupt Pin Unit

This block watches a small group of external interrupt pins and turns their activity into request lines for an interrupt controller. Eight pin positions exist. Positions 1 to 7 are live, and position 0 is reserved and never produces anything. Each live pin first passes through a two-flop synchronizer. Software then picks one of four trigger styles for it: active-low level, rising edge, falling edge, or either edge.

When an edge is detected in an edge mode, the pin's flag bit is latched. It stays set until software writes a 1 to that bit. In level mode, the flag tracks the inverted synchronized pin on every cycle, so an acknowledge there does nothing lasting. A pin's request output is its flag gated by its enable bit.

A simple register port exposes five registers: trigger mode, direction, enable, flag, and pin data. Reads are combinational and writes take effect at the next clock edge. The direction bits are only stored and driven out; the pin driver itself is outside this block.

Top module: `xirq_edge_unit`

## Requirements
- R1: After reset, the mode, direction, enable and flag registers read 0 and every request output is 0.
- R2: The register addresses are 0 mode (16 bits), 1 direction, 2 enable, 3 flag and 4 pin data (read only). Pin p has its 2-bit mode field at bits 2p+1:2p. Bit 0 of every 8-bit register and mode bits 1:0 always read 0, and writes to them are ignored.
- R3: The pin data register shows each synchronized pin value. It reflects a pin change after the second rising clock edge that follows the change.
- R4: In mode 01 (rising), a 0-to-1 transition sets the pin's flag, and a 1-to-0 transition does not.
- R5: In mode 10 (falling), a 1-to-0 transition sets the flag, and a 0-to-1 transition does not.
- R6: In mode 11 (both), any transition sets the flag.
- R7: In mode 00 (level), the flag equals the inverted synchronized pin, so the pin is active low. It appears one cycle after the pin data register shows the change. Writing 1 to the flag has no lasting effect.
- R8: In an edge mode, writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R9: If an edge is detected in the same cycle as a clearing write to that bit, the flag ends up set.
- R10: Each request output equals the pin's flag AND its enable bit. Request bit 0 is always 0.
- R11: The direction register drives the direction output and has no effect on detection.
- R12: In an edge mode, a latched flag stays set after the pin returns to its previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Raw external pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Combinational read data |
| irq_o | output | 8 | Request lines to the interrupt controller |
| dir_o | output | 8 | Stored direction bits |

## Verification
A stale synchronizer or edge-history flop shows up in two ways. A flag may be set for the wrong transition direction, or it may appear one cycle early or late relative to the pin data register. The bench samples both outputs at exact cycle counts after each pin change, so either fault is caught. A flag that clears wrongly or fails to hold becomes visible at the flag read and on the request line within a single cycle of the write.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADR_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_PIN  = 3'd4;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   sync_i,
    input  logic [2*NPIN-1:0] mode_i,
    output logic [NPIN-1:0]   evt_o,
    output logic [NPIN-1:0]   lvl_act_o,
    output logic [NPIN-1:0]   is_lvl_o
);
    logic [NPIN-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sync_i;
        for (int p = 0; p < NPIN; p++) begin
            logic rise, fall;
            rise = sync_i[p] & ~prev_q[p];
            fall = ~sync_i[p] & prev_q[p];
            is_lvl_o[p]  = (trig_e'(mode_i[2*p +: 2]) == TRIG_LEVEL);
            lvl_act_o[p] = ~sync_i[p];
            case (trig_e'(mode_i[2*p +: 2]))
                TRIG_RISE: evt_o[p] = rise;
                TRIG_FALL: evt_o[p] = fall;
                TRIG_BOTH: evt_o[p] = rise | fall;
                default:   evt_o[p] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/xirq_edge_unit.sv
module xirq_edge_unit
    import xirq_pkg::*;
#(
    parameter int NPIN        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pins_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [2*NPIN-1:0] wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [2*NPIN-1:0] rd_data_o,
    output logic [NPIN-1:0]   irq_o,
    output logic [NPIN-1:0]   dir_o
);
    localparam int DW = 2 * NPIN;
    localparam logic [NPIN-1:0] LIVE_MASK = {{(NPIN-1){1'b1}}, 1'b0};
    localparam logic [DW-1:0]   MODE_MASK = {{(DW-2){1'b1}}, 2'b00};

    typedef struct packed {
        logic [DW-1:0]   mode;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] ien;
        logic [NPIN-1:0] flag;
    } regs_t;

    regs_t st_d, st_q;
    logic [NPIN-1:0] pin_s, evt, lvl_act, is_lvl, clr;

    xirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_i),
        .dout (pin_s)
    );

    xirq_detect #(.NPIN(NPIN)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (pin_s),
        .mode_i   (st_q.mode),
        .evt_o    (evt),
        .lvl_act_o(lvl_act),
        .is_lvl_o (is_lvl)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADR_MODE: st_d.mode = wr_data_i & MODE_MASK;
                ADR_DIR:  st_d.dir  = wr_data_i[NPIN-1:0] & LIVE_MASK;
                ADR_IEN:  st_d.ien  = wr_data_i[NPIN-1:0] & LIVE_MASK;
                ADR_FLAG: clr       = wr_data_i[NPIN-1:0];
                default:  ;
            endcase
        end
        for (int p = 0; p < NPIN; p++) begin
            if (is_lvl[p]) st_d.flag[p] = lvl_act[p];
            else           st_d.flag[p] = (st_q.flag[p] & ~clr[p]) | evt[p];
        end
        st_d.flag = st_d.flag & LIVE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_addr_i)
            ADR_MODE: rd_data_o = st_q.mode;
            ADR_DIR:  rd_data_o = {{(DW-NPIN){1'b0}}, st_q.dir};
            ADR_IEN:  rd_data_o = {{(DW-NPIN){1'b0}}, st_q.ien};
            ADR_FLAG: rd_data_o = {{(DW-NPIN){1'b0}}, st_q.flag};
            ADR_PIN:  rd_data_o = {{(DW-NPIN){1'b0}}, pin_s & LIVE_MASK};
            default:  rd_data_o = '0;
        endcase
    end

    assign irq_o = st_q.flag & st_q.ien;
    assign dir_o = st_q.dir;
endmodule

// File: rtl/xirq_edge_unit_chk.sv
module xirq_edge_unit_chk #(
    parameter int NPIN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [2:0]      wr_addr,
    input logic [NPIN-1:1] clr_bits,
    input logic [NPIN-1:1] evt,
    input logic [NPIN-1:1] is_lvl,
    input logic [NPIN-1:1] pin_s,
    input logic [NPIN-1:0] flag_q,
    input logic [NPIN-1:0] irq_o
);
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o[0] == 1'b0) && (flag_q[0] == 1'b0)); // R10

    for (genvar p = 1; p < NPIN; p++) begin : g_pin
        AST_EDGE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[p] && !is_lvl[p]) |=> flag_q[p]); // R9
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == 3'd3 && clr_bits[p] && !evt[p] && !is_lvl[p]) |=> !flag_q[p]); // R8
        AST_FLAG_RETAINS: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && !evt[p] && !is_lvl[p]) |=> (flag_q[p] == $past(flag_q[p]))); // R12
        AST_LEVEL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
            is_lvl[p] |=> (flag_q[p] == !$past(pin_s[p]))); // R7
    end
endmodule

bind xirq_edge_unit xirq_edge_unit_chk #(.NPIN(NPIN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .clr_bits(wr_data_i[NPIN-1:1]),
    .evt     (evt[NPIN-1:1]),
    .is_lvl  (is_lvl[NPIN-1:1]),
    .pin_s   (pin_s[NPIN-1:1]),
    .flag_q  (st_q.flag),
    .irq_o   (irq_o)
);

// File: tb/xirq_edge_unit_tb.sv
module xirq_edge_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = 8'hFF;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  irq, dir;
    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xirq_edge_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .dir_o(dir)
    );

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(3);

        // R1 reset state
        rd(3'd0, v); chk("R1 mode", v, 16'h0000);
        rd(3'd1, v); chk("R1 dir", v, 16'h0000);
        rd(3'd2, v); chk("R1 ien", v, 16'h0000);
        rd(3'd3, v); chk("R1 flag", v, 16'h0000);
        chk("R1 irq", {8'h00, irq}, 16'h0000);
        rd(3'd4, v); chk("R3 pin data idle", v, 16'h00FE);

        // R2 reserved bits
        wr(3'd0, 16'hFFFF); rd(3'd0, v); chk("R2 mode rsvd", v, 16'hFFFC);
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h00FF); rd(3'd2, v); chk("R2 ien rsvd", v, 16'h00FE);
        pins[0] = 1'b0; idle(4);
        rd(3'd4, v); chk("R2 pin bit0", v, 16'h00FE);
        rd(3'd3, v); chk("R2 flag bit0", v, 16'h0000);
        chk("R10 irq bit0", {15'h0, irq[0]}, 16'h0000);
        pins[0] = 1'b1; idle(2);

        // R3 / R7 latency, level mode pin 3
        pins[3] = 1'b0; idle(1);
        rd(3'd4, v); chk("R3 pin after 1 edge", v, 16'h00FE);
        idle(1);
        rd(3'd4, v); chk("R3 pin after 2 edges", v, 16'h00F6);
        rd(3'd3, v); chk("R7 flag after 2 edges", v, 16'h0000);
        idle(1);
        rd(3'd3, v); chk("R7 flag after 3 edges", v, 16'h0008);
        chk("R10 irq level", {8'h00, irq}, 16'h0008);

        // R10 enable gating and R11 direction
        wr(3'd2, 16'h0000); chk("R10 irq gated", {8'h00, irq}, 16'h0000);
        rd(3'd3, v); chk("R10 flag still set", v, 16'h0008);
        wr(3'd1, 16'h00FF); rd(3'd1, v); chk("R11 dir read", v, 16'h00FE);
        chk("R11 dir out", {8'h00, dir}, 16'h00FE);
        rd(3'd3, v); chk("R11 detection unaffected", v, 16'h0008);
        pins[3] = 1'b1; idle(4);
        wr(3'd1, 16'h0000);

        // Sweep: every live pin, every mode, both transitions
        wr(3'd2, 16'h00FE);
        for (int p = 1; p < 8; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int v0 = 0; v0 < 2; v0++) begin
                    logic ex, v1;
                    string rq;
                    v1 = ~v0[0];
                    case (m)
                        0: begin ex = v0[0]; rq = "R7";  end
                        1: begin ex = v1;    rq = "R4";  end
                        2: begin ex = v0[0]; rq = "R5";  end
                        default: begin ex = 1'b1; rq = "R6"; end
                    endcase
                    wr(3'd0, 16'(m) << (2 * p));
                    pins[p] = v0[0]; idle(4);
                    wr(3'd3, 16'h00FF); idle(1);
                    pins[p] = v1; idle(4);
                    rd(3'd3, v); chk(rq, v, 16'(ex) << p);
                    chk("R10 irq", {8'h00, irq}, 16'(ex) << p);
                    wr(3'd3, 16'h0000);
                    rd(3'd3, v); chk("R8 write zero keeps", v, 16'(ex) << p);
                    wr(3'd3, 16'h00FF);
                    rd(3'd3, v);
                    if (m == 0) chk("R7 clear no effect", v, 16'(ex) << p);
                    else        chk("R8 clear", v, 16'h0000);
                    pins[p] = 1'b1; idle(4);
                    wr(3'd0, 16'h0000); idle(1);
                end
            end
        end

        // R12 retention: rising mode pin 5, pulse high then low
        wr(3'd0, 16'h0400);
        pins[5] = 1'b0; idle(4); wr(3'd3, 16'h00FF); idle(1);
        pins[5] = 1'b1; idle(3);
        pins[5] = 1'b0; idle(5);
        rd(3'd3, v); chk("R12 retained", v, 16'h0020);

        // R9 set wins: both mode pin 5, flag already set, clear meets edge
        wr(3'd0, 16'h0C00); idle(1);
        rd(3'd3, v); chk("R9 preset", v, 16'h0020);
        pins[5] = 1'b1; idle(2);
        wr(3'd3, 16'h0020);
        rd(3'd3, v); chk("R9 set wins", v, 16'h0020);
        wr(3'd3, 16'h0020);
        rd(3'd3, v); chk("R8 later clear", v, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule